// File: doc/BRIEF.md
# Timer slave mode controller

This block is a general-purpose up/down counter whose clocking is chosen by a slave mode field. In some modes the counter runs from the internal clock, either freely or under the control of a trigger level or edge. In the encoder modes two quadrature channel inputs both advance the counter and set its direction. The trigger and channel inputs arrive already filtered, polarity-corrected and synchronised. A registered copy of each input gives edge detection that is synchronous to the internal clock.

Counter ticks pass through a programmable prescaler. The counter runs between zero and a programmable auto-reload value. An update output pulses for one cycle when the counter wraps past either end, and when a trigger reinitialises it. The counter value, the current counting direction and the update pulse are all registered outputs. Each of them changes on the clock edge that samples the causing input level.

Top module: `tim_slave_ctrl`

## Requirements
- R1: While rst_ni is low, and on the first sample after it is released, cnt_o is 0, dir_o is 0 and upd_o is 0.
- R2: Mode code 0 (free run): the counter takes one prescaler tick per clock while cnt_en_i is 1 and holds while cnt_en_i is 0. In every mode other than codes 1 to 3, dir_o is 0 (counting up).
- R3: The counter advances once every psc_i+1 prescaler ticks. The first advance comes on the (psc_i+1)-th tick after reset or after a reinitialisation.
- R4: Counting up from a value at or above arr_i gives 0. Counting down from 0 gives arr_i. Each such wrap raises upd_o for exactly that cycle.
- R5: Mode code 1: while cnt_en_i is 1, each change of ch1_i is a tick. It counts up when the new ch1_i differs from ch2_i and down otherwise. dir_o shows 1 for down, updated on each counted tick.
- R6: Mode code 2: while cnt_en_i is 1, each change of ch2_i is a tick. It counts up when the new ch2_i equals ch1_i and down otherwise.
- R7: Mode code 3: changes of either channel are ticks, with direction as in R5 for ch1_i and as in R6 for ch2_i. A cycle in which both channels change counts nothing.
- R8: Mode code 4: a rising edge of trig_i clears the counter and the prescaler and raises upd_o, even while cnt_en_i is 0. Otherwise the mode counts as in R2.
- R9: Mode code 5: the prescaler is ticked on each clock while trig_i is 1 and cnt_en_i is 1. While trig_i is 0 the counter holds its value.
- R10: Mode code 6: the counter stays idle until a rising edge of trig_i. From the next clock on it ticks every clock, without a reset of the count and regardless of trig_i level or cnt_en_i. Leaving the mode stops it.
- R11: Mode code 7: while cnt_en_i is 1, each rising edge of trig_i is one tick.
- R12: Mode code 8: a rising edge of trig_i clears the counter and the prescaler, raises upd_o and starts counting every clock from the next cycle on, independent of cnt_en_i.
- R13: Mode codes 9 to 15 make no ticks and no reinitialisation, so the counter holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_i | input | 1 | Counter enable |
| mode_i | input | 4 | Slave mode code |
| trig_i | input | 1 | Trigger input |
| ch1_i | input | 1 | Channel 1 (quadrature A) |
| ch2_i | input | 1 | Channel 2 (quadrature B) |
| arr_i | input | CNT_W | Auto-reload (top count) value |
| psc_i | input | PSC_W | Prescaler divide value minus one |
| cnt_o | output | CNT_W | Counter value |
| dir_o | output | 1 | Direction, 1 = counting down |
| upd_o | output | 1 | One-cycle update pulse |

## Verification
The hardest situations to reach are a downward wrap through zero in the encoder modes and the cycle in mode 3 where both channels change at once. The stimulus walks a quadrature position forward and then backward past zero in each encoder mode, and finishes mode 3 with a forced jump of both channels. The trigger modes need the rising edge placed against a running count. The bench lets the counter run several cycles before each trigger and fires a second trigger in combined mode while counting is already under way.

// File: rtl/tim_slave_pkg.sv
package tim_slave_pkg;
  typedef enum logic [3:0] {
    MODE_FREE  = 4'd0,
    MODE_ENC1  = 4'd1,
    MODE_ENC2  = 4'd2,
    MODE_ENC3  = 4'd3,
    MODE_RST   = 4'd4,
    MODE_GATE  = 4'd5,
    MODE_START = 4'd6,
    MODE_EXTCK = 4'd7,
    MODE_RSTRT = 4'd8
  } slave_mode_e;

  localparam int unsigned NUM_SIG = 3;
  localparam int unsigned SIG_TRIG = 0;
  localparam int unsigned SIG_CH1  = 1;
  localparam int unsigned SIG_CH2  = 2;
endpackage

// File: rtl/tim_edge_det.sv
module tim_edge_det #(
  parameter int unsigned W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sig_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] chg_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= 1'b0;
      else         prev_q <= sig_i[i];
    end
    assign rise_o[i] = sig_i[i] & ~prev_q;
    assign chg_o[i]  = sig_i[i] ^ prev_q;
  end
endmodule

// File: rtl/tim_mode_ctrl.sv
module tim_mode_ctrl
  import tim_slave_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cnt_en_i,
  input  logic [3:0] mode_i,
  input  logic       trig_i,
  input  logic       ch1_i,
  input  logic       ch2_i,
  input  logic       trig_rise_i,
  input  logic       ch1_chg_i,
  input  logic       ch2_chg_i,
  output logic       tick_o,
  output logic       down_o,
  output logic       reinit_o,
  output logic       dir_o
);
  logic started_q, dir_q;
  logic is_enc, is_start;

  always_comb begin
    tick_o   = 1'b0;
    down_o   = 1'b0;
    reinit_o = 1'b0;
    unique case (mode_i)
      MODE_FREE:  tick_o = cnt_en_i;
      MODE_ENC1: begin
        tick_o = cnt_en_i & ch1_chg_i;
        down_o = (ch1_i == ch2_i);
      end
      MODE_ENC2: begin
        tick_o = cnt_en_i & ch2_chg_i;
        down_o = (ch1_i != ch2_i);
      end
      MODE_ENC3: begin
        // simultaneous change on both channels is ambiguous: dropped
        tick_o = cnt_en_i & (ch1_chg_i ^ ch2_chg_i);
        down_o = ch1_chg_i ? (ch1_i == ch2_i) : (ch1_i != ch2_i);
      end
      MODE_RST: begin
        tick_o   = cnt_en_i;
        reinit_o = trig_rise_i;
      end
      MODE_GATE:  tick_o = cnt_en_i & trig_i;
      MODE_START: tick_o = started_q;
      MODE_EXTCK: tick_o = cnt_en_i & trig_rise_i;
      MODE_RSTRT: begin
        tick_o   = started_q;
        reinit_o = trig_rise_i;
      end
      default: ;
    endcase
  end

  assign is_enc   = (mode_i == MODE_ENC1) || (mode_i == MODE_ENC2) || (mode_i == MODE_ENC3);
  assign is_start = (mode_i == MODE_START) || (mode_i == MODE_RSTRT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started_q <= 1'b0;
      dir_q     <= 1'b0;
    end else begin
      started_q <= is_start & (started_q | trig_rise_i);
      if (!is_enc)     dir_q <= 1'b0;
      else if (tick_o) dir_q <= down_o;
    end
  end

  assign dir_o = dir_q;

  assert_enc3_both_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_ENC3 && ch1_chg_i && ch2_chg_i) |-> !tick_o);
endmodule

// File: rtl/tim_counter.sv
module tim_counter #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PSC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             down_i,
  input  logic             reinit_i,
  input  logic [CNT_W-1:0] arr_i,
  input  logic [PSC_W-1:0] psc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             upd_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [PSC_W-1:0] psc_q;
  logic             upd_q;
  logic             step;

  assign step = tick_i && (psc_q == psc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      psc_q <= '0;
      upd_q <= 1'b0;
    end else begin
      upd_q <= 1'b0;
      if (reinit_i) begin
        cnt_q <= '0;
        psc_q <= '0;
        upd_q <= 1'b1;
      end else if (tick_i) begin
        if (step) begin
          psc_q <= '0;
          if (down_i) begin
            if (cnt_q == '0) begin
              cnt_q <= arr_i;
              upd_q <= 1'b1;
            end else begin
              cnt_q <= cnt_q - 1'b1;
            end
          end else if (cnt_q >= arr_i) begin
            cnt_q <= '0;
            upd_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end else begin
          psc_q <= psc_q + 1'b1;
        end
      end
    end
  end

  assign cnt_o = cnt_q;
  assign upd_o = upd_q;

  assert_up_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && !reinit_i && !down_i && cnt_q >= arr_i) |=> (cnt_q == '0 && upd_o));
  assert_down_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && !reinit_i && down_i && cnt_q == '0) |=> (cnt_q == $past(arr_i) && upd_o));
  assert_reinit_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reinit_i |=> (cnt_q == '0 && psc_q == '0 && upd_o));
endmodule

// File: rtl/tim_slave_ctrl.sv
module tim_slave_ctrl
  import tim_slave_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PSC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_en_i,
  input  logic [3:0]       mode_i,
  input  logic             trig_i,
  input  logic             ch1_i,
  input  logic             ch2_i,
  input  logic [CNT_W-1:0] arr_i,
  input  logic [PSC_W-1:0] psc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dir_o,
  output logic             upd_o
);
  logic [NUM_SIG-1:0] sig, rise, chg;
  logic tick, down, reinit;

  assign sig[SIG_TRIG] = trig_i;
  assign sig[SIG_CH1]  = ch1_i;
  assign sig[SIG_CH2]  = ch2_i;

  tim_edge_det #(.W(NUM_SIG)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (sig),
    .rise_o (rise),
    .chg_o  (chg)
  );

  tim_mode_ctrl u_mode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cnt_en_i    (cnt_en_i),
    .mode_i      (mode_i),
    .trig_i      (trig_i),
    .ch1_i       (ch1_i),
    .ch2_i       (ch2_i),
    .trig_rise_i (rise[SIG_TRIG]),
    .ch1_chg_i   (chg[SIG_CH1]),
    .ch2_chg_i   (chg[SIG_CH2]),
    .tick_o      (tick),
    .down_o      (down),
    .reinit_o    (reinit),
    .dir_o       (dir_o)
  );

  tim_counter #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .down_i   (down),
    .reinit_i (reinit),
    .arr_i    (arr_i),
    .psc_i    (psc_i),
    .cnt_o    (cnt_o),
    .upd_o    (upd_o)
  );

  logic unused_rise;
  assign unused_rise = ^{rise[SIG_CH1], rise[SIG_CH2], chg[SIG_TRIG]};

  assert_gate_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_GATE && !trig_i && $stable(arr_i)) |=> $stable(cnt_o));
  assert_bad_mode_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i > MODE_RSTRT) |=> ($stable(cnt_o) && !upd_o));
  assert_dir_up_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_FREE || mode_i > MODE_ENC3) |=> !dir_o);
endmodule

// File: tb/tim_slave_ctrl_tb.sv
module tim_slave_ctrl_tb;
  localparam int CNT_W = 16;
  localparam int PSC_W = 16;

  logic             clk = 1'b0;
  logic             rst_ni;
  logic             cnt_en;
  logic [3:0]       mode;
  logic             trig, ch1, ch2;
  logic [CNT_W-1:0] arr;
  logic [PSC_W-1:0] psc;
  logic [CNT_W-1:0] cnt_o;
  logic             dir_o, upd_o;

  int total = 0;
  int bad = 0;

  // bench model state
  int m_cnt, m_psc;
  bit m_dir, m_upd, m_st, pt, p1, p2;
  int pos;

  always #4 clk = ~clk;

  tim_slave_ctrl #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cnt_en_i(cnt_en), .mode_i(mode),
    .trig_i(trig), .ch1_i(ch1), .ch2_i(ch2), .arr_i(arr), .psc_i(psc),
    .cnt_o(cnt_o), .dir_o(dir_o), .upd_o(upd_o)
  );

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic do_reset(string req);
    @(negedge clk);
    rst_ni = 1'b0;
    cnt_en = 1'b0; mode = 4'd0; trig = 1'b0; ch1 = 1'b0; ch2 = 1'b0;
    arr = 16'd5; psc = 16'd0;
    m_cnt = 0; m_psc = 0; m_dir = 0; m_upd = 0; m_st = 0; pt = 0; p1 = 0; p2 = 0;
    repeat (3) @(negedge clk);
    check(req, "cnt in reset", int'(cnt_o), 0);
    rst_ni = 1'b1;
    @(posedge clk); @(negedge clk);
    check(req, "cnt", int'(cnt_o), 0);
    check(req, "dir", int'(dir_o), 0);
    check(req, "upd", int'(upd_o), 0);
  endtask

  // drive one cycle at a falling edge, advance the model, compare after the next rising edge
  task automatic step(bit t, bit c1, bit c2, string req);
    bit rt, e1, e2, tk, dn, ri;
    trig = t; ch1 = c1; ch2 = c2;
    rt = t & ~pt; e1 = c1 ^ p1; e2 = c2 ^ p2;
    tk = 0; dn = 0; ri = 0;
    case (int'(mode))
      0: tk = cnt_en;
      1: begin tk = cnt_en & e1; dn = (c1 == c2); end
      2: begin tk = cnt_en & e2; dn = (c1 != c2); end
      3: begin tk = cnt_en & (e1 ^ e2); dn = e1 ? (c1 == c2) : (c1 != c2); end
      4: begin tk = cnt_en; ri = rt; end
      5: tk = cnt_en & t;
      6: tk = m_st;
      7: tk = cnt_en & rt;
      8: begin tk = m_st; ri = rt; end
      default: ;
    endcase
    m_st = (mode == 4'd6 || mode == 4'd8) ? (m_st | rt) : 1'b0;
    if (mode >= 4'd1 && mode <= 4'd3) begin
      if (tk) m_dir = dn;
    end else m_dir = 0;
    m_upd = 0;
    if (ri) begin
      m_cnt = 0; m_psc = 0; m_upd = 1;
    end else if (tk) begin
      if (m_psc == int'(psc)) begin
        m_psc = 0;
        if (dn) begin
          if (m_cnt == 0) begin m_cnt = int'(arr); m_upd = 1; end
          else m_cnt--;
        end else if (m_cnt >= int'(arr)) begin m_cnt = 0; m_upd = 1; end
        else m_cnt++;
      end else m_psc++;
    end
    pt = t; p1 = c1; p2 = c2;
    @(posedge clk); @(negedge clk);
    check(req, "cnt", int'(cnt_o), m_cnt);
    check(req, "dir", int'(dir_o), int'(m_dir));
    check(req, "upd", int'(upd_o), int'(m_upd));
  endtask

  function automatic bit [1:0] quad(int p);
    case (p % 4)
      0: return 2'b00;
      1: return 2'b10;
      2: return 2'b11;
      default: return 2'b01;
    endcase
  endfunction

  task automatic enc_walk(string req);
    bit [1:0] q;
    for (int i = 0; i < 14; i++) begin
      pos++; q = quad(pos); step(1'b0, q[1], q[0], req);
    end
    for (int i = 0; i < 30; i++) begin
      pos--; q = quad(pos); step(1'b0, q[1], q[0], req);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_ni = 1'b0;
    do_reset("R1");

    // R2/R4: free run, wrap at arr, hold while disabled
    cnt_en = 1'b1;
    for (int i = 0; i < 14; i++) step(0, 0, 0, "R2_R4");
    cnt_en = 1'b0;
    for (int i = 0; i < 3; i++) step(0, 0, 0, "R2 hold");
    for (int a = 0; a < 3; a++) begin
      do_reset("R1"); arr = 16'(a); cnt_en = 1'b1;
      for (int i = 0; i < 8; i++) step(0, 0, 0, "R4 small arr");
    end

    // R3: prescaler sweep
    for (int p = 1; p < 4; p++) begin
      do_reset("R1"); psc = 16'(p); cnt_en = 1'b1;
      for (int i = 0; i < 20; i++) step(0, 0, 0, "R3");
    end

    // R5/R6/R7: encoder walks forward, then backward through zero
    for (int m = 1; m <= 3; m++) begin
      do_reset("R1"); mode = 4'(m); cnt_en = 1'b1; pos = 100;
      enc_walk(m == 1 ? "R5" : (m == 2 ? "R6" : "R7"));
    end
    step(0, 1, 1, "R7 both change");
    step(0, 0, 0, "R7 both change");
    step(0, 1, 0, "R7 single");
    cnt_en = 1'b0;
    step(0, 1, 1, "R5 disabled");

    // R8: reset mode
    do_reset("R1"); mode = 4'd4; cnt_en = 1'b1;
    for (int i = 0; i < 4; i++) step(0, 0, 0, "R8");
    step(1, 0, 0, "R8 rise");
    for (int i = 0; i < 3; i++) step(1, 0, 0, "R8 high");
    step(0, 0, 0, "R8"); cnt_en = 1'b0;
    step(1, 0, 0, "R8 rise disabled");
    step(0, 0, 0, "R8");

    // R9: gated
    do_reset("R1"); mode = 4'd5; cnt_en = 1'b1;
    for (int i = 0; i < 16; i++) step(bit'((i / 3) % 2), 0, 0, "R9");

    // R10: start-on-trigger
    do_reset("R1"); mode = 4'd6;
    for (int i = 0; i < 3; i++) step(0, 0, 0, "R10 idle");
    step(1, 0, 0, "R10 rise");
    for (int i = 0; i < 9; i++) step(0, 0, 0, "R10 run");
    mode = 4'd13;
    step(0, 0, 0, "R10 leave");

    // R11: external clock
    do_reset("R1"); mode = 4'd7; cnt_en = 1'b1;
    for (int i = 0; i < 16; i++) step(bit'(i % 2), 0, 0, "R11");

    // R12: combined
    do_reset("R1"); mode = 4'd8;
    for (int i = 0; i < 2; i++) step(0, 0, 0, "R12 idle");
    step(1, 0, 0, "R12 rise");
    for (int i = 0; i < 8; i++) step(0, 0, 0, "R12 run");
    step(1, 0, 0, "R12 re-rise");
    for (int i = 0; i < 3; i++) step(0, 0, 0, "R12 run");

    // R13: undefined codes
    for (int m = 9; m < 16; m++) begin
      do_reset("R1"); mode = 4'd0; cnt_en = 1'b1;
      step(0, 0, 0, "R2");
      mode = 4'(m);
      for (int i = 0; i < 4; i++) step(bit'(i % 2), bit'(i % 2), 0, "R13");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule